// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This unit carries out the 16-bit operations a small 8-bit processor performs on its register pairs: increment a pair, decrement a pair, and add a pair into the HL pair. Each pair is treated as a high byte and a low byte. The unit chains the byte sums so that a carry or borrow moves from the low byte into the high byte. The register file, instruction decode and memory access are outside the unit. The caller presents the selected pair value, the HL value, the current carry flag, the operation code and the code of the pair it read.

One clock after an accepted request, the unit presents four outputs. These are the 16-bit result, the code of the pair that should receive it, a carry-flag value and a carry-flag write-enable. Increment and decrement of a pair write back to the pair they read and never request a flag write. The double add always writes HL and updates only the carry flag. The unit has no enable for any other flag, so the sign, zero, parity and half-carry flags are left as they were.

Top module: `rp_arith_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs `res_valid`, `res_val`, `res_dest`, `cy_we` and `cy_out` are all zero after that edge.
- R2: A request is accepted at a rising edge where `op_valid` is 1 and `op_sel` is not 2'b11. Its outputs appear after that same edge, and `res_valid` is 1 for exactly that cycle.
- R3: The increment code (`op_sel` = 2'b00) gives `res_val` = `pair_val` + 1 modulo 2^16. A carry out of the low byte propagates into the high byte, and 16'hFFFF wraps to 16'h0000. `res_dest` equals `pair_sel`.
- R4: The decrement code (`op_sel` = 2'b01) gives `res_val` = `pair_val` - 1 modulo 2^16. A borrow is taken from the high byte when the low byte is zero, and 16'h0000 wraps to 16'hFFFF. `res_dest` equals `pair_sel`.
- R5: For increment and decrement, `cy_we` is 0 and `cy_out` equals the `carry_in` sampled with the request, so the flag is left unchanged.
- R6: The double-add code (`op_sel` = 2'b10) gives `res_val` = (`pair_val` + `hl_val`) modulo 2^16. `res_dest` is the HL code 2'b10, `cy_we` is 1, and `cy_out` is the carry out of bit 15. `carry_in` is not added.
- R7: For a double add with `pair_sel` = 2'b10 (HL), the unit uses `hl_val` as both operands and doubles HL. `pair_val` has no effect on the result.
- R8: An edge with `op_valid` = 0, or with the reserved code `op_sel` = 2'b11, yields `res_valid` = 0 and `cy_we` = 0 in the next cycle.
- R9: Pair codes are 2'b00 BC, 2'b01 DE, 2'b10 HL and 2'b11 SP. For a double add with any pair code other than HL, `pair_val` is the addend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation: 00 increment, 01 decrement, 10 double add, 11 reserved |
| pair_sel | input | 2 | Code of the pair that supplied `pair_val` |
| pair_val | input | 16 | Selected register-pair value (high byte in bits 15:8) |
| hl_val | input | 16 | Current HL pair value |
| carry_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Result present this cycle |
| res_val | output | 16 | 16-bit result |
| res_dest | output | 2 | Pair code that receives `res_val` |
| cy_we | output | 1 | Carry-flag write-enable |
| cy_out | output | 1 | Carry-flag value |

## Verification
The properties assume the request fields are stable for the whole edge at which `op_valid` is sampled. They also assume the caller pairs `pair_sel` = HL with a matching `pair_val`, or else does not care about it. The R7 property compares only against `hl_val`, so it accepts a mismatched `pair_val` by design. The directed bench drives every input at the falling edge and holds it through the following rising edge. It deliberately gives `pair_val` a different value from `hl_val` in the HL-doubling case, to show that `pair_val` is ignored.

// File: rtl/rpau_pkg.sv
package rpau_pkg;

  typedef enum logic [1:0] {
    RP_INC = 2'b00,
    RP_DEC = 2'b01,
    RP_DAD = 2'b10,
    RP_RSV = 2'b11
  } rp_op_e;

  typedef enum logic [1:0] {
    PR_BC = 2'b00,
    PR_DE = 2'b01,
    PR_HL = 2'b10,
    PR_SP = 2'b11
  } rp_pair_e;

endpackage

// File: rtl/rpau_byte_slice.sv
module rpau_byte_slice #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              cin,
  output logic [BYTE_W-1:0] sum,
  output logic              cout
);
  logic [BYTE_W:0] total;

  assign total = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, cin};
  assign sum   = total[BYTE_W-1:0];
  assign cout  = total[BYTE_W];
endmodule

// File: rtl/rpau_byte_chain.sv
module rpau_byte_chain #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic [BYTE_W*NBYTES-1:0] a,
  input  logic [BYTE_W*NBYTES-1:0] b,
  output logic [BYTE_W*NBYTES-1:0] sum,
  output logic                     cout
);
  logic [NBYTES:0] carry;

  assign carry[0] = 1'b0;

  // Each byte takes the carry of the byte below it, low byte first.
  for (genvar g = 0; g < NBYTES; g++) begin : g_slice
    rpau_byte_slice #(.BYTE_W(BYTE_W)) slice_i (
      .a   (a[g*BYTE_W +: BYTE_W]),
      .b   (b[g*BYTE_W +: BYTE_W]),
      .cin (carry[g]),
      .sum (sum[g*BYTE_W +: BYTE_W]),
      .cout(carry[g+1])
    );
  end

  assign cout = carry[NBYTES];
endmodule

// File: rtl/rpau_opnd_sel.sv
module rpau_opnd_sel
  import rpau_pkg::*;
#(
  parameter int PAIR_W = 16
) (
  input  logic [1:0]        op_sel,
  input  logic [1:0]        pair_sel,
  input  logic [PAIR_W-1:0] pair_val,
  input  logic [PAIR_W-1:0] hl_val,
  output logic [PAIR_W-1:0] opa,
  output logic [PAIR_W-1:0] opb
);
  localparam logic [PAIR_W-1:0] ONE  = PAIR_W'(1);
  localparam logic [PAIR_W-1:0] ONES = {PAIR_W{1'b1}};

  always_comb begin
    opa = '0;
    opb = '0;
    unique case (rp_op_e'(op_sel))
      RP_INC: begin
        opa = pair_val;
        opb = ONE;
      end
      RP_DEC: begin
        // Subtracting one is adding all ones; the final carry is discarded.
        opa = pair_val;
        opb = ONES;
      end
      RP_DAD: begin
        opa = (rp_pair_e'(pair_sel) == PR_HL) ? hl_val : pair_val;
        opb = hl_val;
      end
      default: begin
        opa = '0;
        opb = '0;
      end
    endcase
  end
endmodule

// File: rtl/rp_arith_unit.sv
module rp_arith_unit
  import rpau_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_valid,
  input  logic [1:0]               op_sel,
  input  logic [1:0]               pair_sel,
  input  logic [BYTE_W*NBYTES-1:0] pair_val,
  input  logic [BYTE_W*NBYTES-1:0] hl_val,
  input  logic                     carry_in,
  output logic                     res_valid,
  output logic [BYTE_W*NBYTES-1:0] res_val,
  output logic [1:0]               res_dest,
  output logic                     cy_we,
  output logic                     cy_out
);
  localparam int PAIR_W = BYTE_W * NBYTES;

  logic [PAIR_W-1:0] opa;
  logic [PAIR_W-1:0] opb;
  logic [PAIR_W-1:0] sum;
  logic              sum_cout;
  logic              accept;
  logic              is_dad;

  rpau_opnd_sel #(.PAIR_W(PAIR_W)) opnd_i (
    .op_sel  (op_sel),
    .pair_sel(pair_sel),
    .pair_val(pair_val),
    .hl_val  (hl_val),
    .opa     (opa),
    .opb     (opb)
  );

  rpau_byte_chain #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) chain_i (
    .a   (opa),
    .b   (opb),
    .sum (sum),
    .cout(sum_cout)
  );

  assign accept = op_valid && (rp_op_e'(op_sel) != RP_RSV);
  assign is_dad = rp_op_e'(op_sel) == RP_DAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_val   <= '0;
      res_dest  <= 2'b00;
      cy_we     <= 1'b0;
      cy_out    <= 1'b0;
    end else begin
      res_valid <= accept;
      cy_we     <= accept && is_dad;
      if (accept) begin
        res_val  <= sum;
        res_dest <= is_dad ? 2'(PR_HL) : pair_sel;
        cy_out   <= is_dad ? sum_cout : carry_in;
      end
    end
  end
endmodule

// File: rtl/rp_arith_unit_chk.sv
module rp_arith_unit_chk #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     op_valid,
  input logic [1:0]               op_sel,
  input logic [1:0]               pair_sel,
  input logic [BYTE_W*NBYTES-1:0] pair_val,
  input logic [BYTE_W*NBYTES-1:0] hl_val,
  input logic                     carry_in,
  input logic                     res_valid,
  input logic [BYTE_W*NBYTES-1:0] res_val,
  input logic [1:0]               res_dest,
  input logic                     cy_we,
  input logic                     cy_out
);
  localparam int PW = BYTE_W * NBYTES;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && !cy_we && res_val == '0 && res_dest == 2'b00 && !cy_out));

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel != 2'b11) |=> res_valid);

  // R8
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel == 2'b11) |=> (!res_valid && !cy_we));

  // R3
  a_r3_inc_value: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b00) |=>
      (res_val == PW'($past(pair_val) + 1'b1) && res_dest == $past(pair_sel)));

  // R4
  a_r4_dec_value: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b01) |=>
      (res_val == PW'($past(pair_val) - 1'b1) && res_dest == $past(pair_sel)));

  // R5
  a_r5_no_flag_write: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel[1] == 1'b0) |=> (!cy_we && cy_out == $past(carry_in)));

  // R6, R9
  a_r6_dad_sum: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b10 && pair_sel != 2'b10) |=>
      ({cy_out, res_val} == ({1'b0, $past(pair_val)} + {1'b0, $past(hl_val)})
       && cy_we && res_dest == 2'b10));

  // R7
  a_r7_dad_double: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b10 && pair_sel == 2'b10) |=>
      ({cy_out, res_val} == {$past(hl_val), 1'b0} && cy_we));
endmodule

bind rp_arith_unit rp_arith_unit_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) chk_i (.*);

// File: tb/rp_arith_unit_tb_top.sv
module rp_arith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_sel;
  logic [1:0]  pair_sel;
  logic [15:0] pair_val;
  logic [15:0] hl_val;
  logic        carry_in;
  logic        res_valid;
  logic [15:0] res_val;
  logic [1:0]  res_dest;
  logic        cy_we;
  logic        cy_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rp_arith_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .pair_sel(pair_sel), .pair_val(pair_val), .hl_val(hl_val),
    .carry_in(carry_in), .res_valid(res_valid), .res_val(res_val),
    .res_dest(res_dest), .cy_we(cy_we), .cy_out(cy_out)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one request at the falling edge and sample one clock later.
  task automatic issue(input logic v, input logic [1:0] op, input logic [1:0] ps,
                       input logic [15:0] pv, input logic [15:0] hv, input logic ci);
    @(negedge clk);
    op_valid = v; op_sel = op; pair_sel = ps;
    pair_val = pv; hl_val = hv; carry_in = ci;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; op_valid = 1'b0; op_sel = 2'b00; pair_sel = 2'b00;
    pair_val = '0; hl_val = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, res_valid}, 32'd0);
    check("R1 value", {16'b0, res_val}, 32'd0);
    check("R1 dest/flag", {27'b0, res_dest, cy_we, cy_out}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_inc(input logic [1:0] ps, input logic [15:0] pv, input logic ci);
    issue(1'b1, 2'b00, ps, pv, 16'h5A5A, ci);
    check("R2 inc valid", {31'b0, res_valid}, 32'd1);
    check("R3 inc value", {16'b0, res_val}, {16'b0, 16'(pv + 16'd1)});
    check("R3 inc dest", {30'b0, res_dest}, {30'b0, ps});
    check("R5 inc flags", {30'b0, cy_we, cy_out}, {30'b0, 1'b0, ci});
  endtask

  task automatic t_dec(input logic [1:0] ps, input logic [15:0] pv, input logic ci);
    issue(1'b1, 2'b01, ps, pv, 16'hA5A5, ci);
    check("R4 dec value", {16'b0, res_val}, {16'b0, 16'(pv - 16'd1)});
    check("R4 dec dest", {30'b0, res_dest}, {30'b0, ps});
    check("R5 dec flags", {30'b0, cy_we, cy_out}, {30'b0, 1'b0, ci});
  endtask

  task automatic t_dad(input logic [1:0] ps, input logic [15:0] pv, input logic [15:0] hv,
                       input logic ci);
    logic [16:0] exp;
    exp = {1'b0, pv} + {1'b0, hv};
    issue(1'b1, 2'b10, ps, pv, hv, ci);
    check("R6 dad value", {16'b0, res_val}, {16'b0, exp[15:0]});
    check("R6 dad carry", {30'b0, cy_we, cy_out}, {30'b0, 1'b1, exp[16]});
    check("R6 dad dest", {30'b0, res_dest}, 32'd2);
  endtask

  task automatic t_dad_hl(input logic [15:0] hv, input logic [15:0] junk);
    logic [16:0] exp;
    exp = {hv, 1'b0};
    issue(1'b1, 2'b10, 2'b10, junk, hv, 1'b0);
    check("R7 double value", {16'b0, res_val}, {16'b0, exp[15:0]});
    check("R7 double carry", {31'b0, cy_out}, {31'b0, exp[16]});
  endtask

  task automatic t_idle();
    issue(1'b0, 2'b10, 2'b00, 16'hFFFF, 16'h0001, 1'b1);
    check("R8 no valid", {30'b0, res_valid, cy_we}, 32'd0);
    issue(1'b1, 2'b11, 2'b00, 16'hFFFF, 16'h0001, 1'b1);
    check("R8 reserved", {30'b0, res_valid, cy_we}, 32'd0);
    @(negedge clk);
    check("R2 single pulse", {31'b0, res_valid}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_inc(2'b00, 16'h1234, 1'b0);
    t_inc(2'b01, 16'h00FF, 1'b1);   // carry low -> high byte
    t_inc(2'b11, 16'hFFFF, 1'b1);   // wrap to zero
    t_dec(2'b00, 16'h1200, 1'b1);   // borrow from high byte
    t_dec(2'b01, 16'h0000, 1'b0);   // wrap to all ones
    t_dec(2'b10, 16'h8001, 1'b1);
    t_dad(2'b00, 16'h1234, 16'h1111, 1'b1);  // R6 carry_in not added
    t_dad(2'b01, 16'h00FF, 16'h0001, 1'b0);  // R9 DE as addend
    t_dad(2'b11, 16'hFFFF, 16'h0001, 1'b0);  // R9 SP, carry out
    t_dad(2'b00, 16'h8000, 16'h8000, 1'b0);
    t_dad_hl(16'h4321, 16'h0F0F);
    t_dad_hl(16'h8001, 16'hFFFF);
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule